// File: doc/BRIEF.md
# Queue Fill-Level Watermark Monitor

This block watches the byte occupancy of one packet queue and the overflow indications of that queue and of its input FIFO. Two programmable thresholds, high and low, are set in coarse 64 KiB steps. Each threshold has a comparator with edge detection, so a crossing raises an event once. It does not raise the event again on every cycle that the level stays past the threshold.

Four events are held in sticky status bits: low crossing, high crossing, queue overflow and FIFO overflow. Each bit has its own enable. The interrupt line is a level that stays asserted while any enabled bit is set. Software programs and observes the block over a byte-wide register bus. Reading the status register returns the flags and clears them.

Top module: `qlevel_watch`

## Requirements
- R1: After reset the high threshold, low threshold, interrupt enables and status flags are all zero, `irq_o` is low and `rdata_o` is zero.
- R2: The high threshold is a full 8-bit read/write register at address 0x125, and the low threshold is one at 0x124. A value T stands for a byte level of T × 65536.
- R3: Status bit 1 sets when occupancy goes from at or below the high level to above it. Occupancy equal to the level is not above it. The flag is visible one clock after the occupancy change.
- R4: While occupancy stays above the high level, no further high-crossing event is raised.
- R5: Status bit 0 sets when occupancy goes from at or above the low level to below it. Occupancy equal to the level is not below it.
- R6: A one-cycle `q_ovf_i` pulse sets status bit 2, and a one-cycle `f_ovf_i` pulse sets status bit 3.
- R7: Status bits stay set until the status register at 0x127 is read. That read returns the flags and clears them. A read at any other address clears nothing.
- R8: If an event occurs in the same cycle as a status read, the event's bit is set after the read. The read itself returns the value held before the event.
- R9: The interrupt-enable register at 0x126 keeps bits 3:0, which use the same bit positions as the status bits. Bits 7:4 of the enable register and of the status register read as zero. Writes to the status address have no effect.
- R10: `irq_o` is high exactly when some status bit is set and its enable bit is also set.
- R11: Read data appears on `rdata_o` in the cycle after a one-cycle `rd_i` strobe and holds until the next strobe. An unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| occ_i | input | 24 | Queue byte occupancy |
| q_ovf_i | input | 1 | Queue overflow pulse |
| f_ovf_i | input | 1 | Input FIFO overflow pulse |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 9 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Level interrupt |

## Verification
A change of occupancy or an overflow pulse shows up in the status flags, and so on `irq_o`, one clock later. The bench drives every input on the falling edge and checks `irq_o` on each following falling edge against a model of the flags that the bench updates at every rising edge. A read result is due on `rdata_o` one clock after the strobe, so each read task raises `rd_i` for one cycle and compares on the next falling edge, when the clear-on-read has also taken effect. Sweeps over a grid of thresholds drive occupancy to just below, exactly at and just above each level, so that the strict-inequality boundaries are hit.

// File: rtl/qlevel_pkg.sv
package qlevel_pkg;
  localparam int unsigned FLAG_N = 4;
  localparam int unsigned EV_LOW  = 0;
  localparam int unsigned EV_HIGH = 1;
  localparam int unsigned EV_QOVF = 2;
  localparam int unsigned EV_FOVF = 3;

  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/qlevel_regs.sv
module qlevel_regs
  import qlevel_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_LO = 9'h124,
  parameter logic [ADDR_W-1:0] ADDR_HI = 9'h125,
  parameter logic [ADDR_W-1:0] ADDR_IE = 9'h126,
  parameter logic [ADDR_W-1:0] ADDR_ST = 9'h127
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  flag_vec_t         status_i,
  output logic [DATA_W-1:0] lo_thr_o,
  output logic [DATA_W-1:0] hi_thr_o,
  output flag_vec_t         ie_o,
  output logic              st_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] lo_q, hi_q, rd_mux;
  flag_vec_t         ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
      ie_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_LO) lo_q <= wdata_i;
      if (addr_i == ADDR_HI) hi_q <= wdata_i;
      if (addr_i == ADDR_IE) ie_q <= wdata_i[FLAG_N-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_LO) rd_mux = lo_q;
    if (addr_i == ADDR_HI) rd_mux = hi_q;
    if (addr_i == ADDR_IE) rd_mux = DATA_W'(ie_q);
    if (addr_i == ADDR_ST) rd_mux = DATA_W'(status_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign st_clr_o = rd_i && (addr_i == ADDR_ST);
  assign lo_thr_o = lo_q;
  assign hi_thr_o = hi_q;
  assign ie_o     = ie_q;
endmodule

// File: rtl/qlevel_cross.sv
module qlevel_cross #(
  parameter int unsigned OCC_W     = 24,
  parameter int unsigned THR_W     = 8,
  parameter int unsigned STEP_LOG2 = 16,
  parameter bit          ABOVE     = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             evt_o
);
  localparam int unsigned CMP_W = (OCC_W > THR_W + STEP_LOG2) ? OCC_W : THR_W + STEP_LOG2;

  logic [CMP_W-1:0] occ_ext, lvl;
  logic             past_now, past_q;

  assign occ_ext = CMP_W'(occ_i);
  assign lvl     = CMP_W'(thr_i) << STEP_LOG2;

  generate
    if (ABOVE) begin : g_above
      assign past_now = occ_ext > lvl;
    end else begin : g_below
      assign past_now = occ_ext < lvl;
    end
  endgenerate

  // previous comparison taken as "not past" out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_q <= 1'b0;
    else         past_q <= past_now;
  end

  assign evt_o = past_now && !past_q;
endmodule

// File: rtl/qlevel_flags.sv
module qlevel_flags
  import qlevel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t evt_i,
  input  logic      clr_i,
  input  flag_vec_t ie_i,
  output flag_vec_t status_o,
  output logic      irq_o
);
  flag_vec_t st_q;

  // set beats clear so a coincident event survives the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (clr_i ? '0 : st_q) | evt_i;
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & ie_i);
endmodule

// File: rtl/qlevel_watch.sv
module qlevel_watch
  import qlevel_pkg::*;
#(
  parameter int unsigned OCC_W     = 24,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STEP_LOG2 = 16,
  parameter logic [ADDR_W-1:0] ADDR_LO = 9'h124,
  parameter logic [ADDR_W-1:0] ADDR_HI = 9'h125,
  parameter logic [ADDR_W-1:0] ADDR_IE = 9'h126,
  parameter logic [ADDR_W-1:0] ADDR_ST = 9'h127
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic              q_ovf_i,
  input  logic              f_ovf_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [1:0][DATA_W-1:0] thr;
  logic [1:0]             cross_evt;
  flag_vec_t              status_q, ie_q, evt;
  logic                   st_clr;

  qlevel_regs #(
    .ADDR_W (ADDR_W),  .DATA_W (DATA_W),
    .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI),
    .ADDR_IE(ADDR_IE), .ADDR_ST(ADDR_ST)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(status_q),
    .lo_thr_o(thr[0]),
    .hi_thr_o(thr[1]),
    .ie_o    (ie_q),
    .st_clr_o(st_clr),
    .rdata_o (rdata_o)
  );

  // index 0: falling through low level, index 1: rising through high level
  for (genvar g = 0; g < 2; g++) begin : g_cross
    qlevel_cross #(
      .OCC_W    (OCC_W),
      .THR_W    (DATA_W),
      .STEP_LOG2(STEP_LOG2),
      .ABOVE    (g == 1)
    ) u_cross (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .occ_i (occ_i),
      .thr_i (thr[g]),
      .evt_o (cross_evt[g])
    );
  end

  always_comb begin
    evt          = '0;
    evt[EV_LOW]  = cross_evt[0];
    evt[EV_HIGH] = cross_evt[1];
    evt[EV_QOVF] = q_ovf_i;
    evt[EV_FOVF] = f_ovf_i;
  end

  qlevel_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (st_clr),
    .ie_i    (ie_q),
    .status_o(status_q),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/qlevel_watch_chk.sv
module qlevel_watch_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_IE = 9'h126,
  parameter logic [ADDR_W-1:0] ADDR_ST = 9'h127
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              q_ovf_i,
  input logic              f_ovf_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [3:0]        status_q,
  input logic [3:0]        ie_q
);
  logic st_rd;
  assign st_rd = rd_i && (addr_i == ADDR_ST);

  p_qovf_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_ovf_i |=> status_q[2]);

  p_fovf_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_ovf_i |=> status_q[3]);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_rd |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd && !q_ovf_i && !f_ovf_i) |=> (status_q[3:2] == 2'b00));

  p_event_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd && q_ovf_i) |=> status_q[2]);

  p_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == ADDR_IE || addr_i == ADDR_ST)) |=> (rdata_o[DATA_W-1:4] == '0));

  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == 4'h0) |-> !irq_o);

  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != 4'h0));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind qlevel_watch qlevel_watch_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ADDR_IE(ADDR_IE),
  .ADDR_ST(ADDR_ST)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .q_ovf_i (q_ovf_i),
  .f_ovf_i (f_ovf_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .status_q(status_q),
  .ie_q    (ie_q)
);

// File: tb/qlevel_watch_test.sv
module qlevel_watch_test;
  localparam int unsigned S = 65536;
  localparam logic [8:0] A_LO = 9'h124, A_HI = 9'h125, A_IE = 9'h126, A_ST = 9'h127;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] occ = '0;
  logic        q_ovf = 1'b0, f_ovf = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [8:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit irq_auto = 1'b0;

  always #10 clk = ~clk;

  qlevel_watch uut (
    .clk_i(clk), .rst_ni(rst_n), .occ_i(occ), .q_ovf_i(q_ovf), .f_ovf_i(f_ovf),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // spec model of the register state, updated at each rising edge
  logic [7:0] hi_m, lo_m, exp_rd;
  logic [3:0] ie_m, st_m;
  logic       pa, pb, m_above, m_below;

  always_comb begin
    m_above = 32'(occ) > (32'(hi_m) * S);
    m_below = 32'(occ) < (32'(lo_m) * S);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_m <= '0; lo_m <= '0; ie_m <= '0; st_m <= '0;
      pa <= 1'b0; pb <= 1'b0; exp_rd <= '0;
    end else begin
      st_m <= ((rd && addr == A_ST) ? 4'h0 : st_m) |
              {f_ovf, q_ovf, m_above && !pa, m_below && !pb};
      pa <= m_above;
      pb <= m_below;
      if (wr) begin
        if (addr == A_HI) hi_m <= wdata;
        if (addr == A_LO) lo_m <= wdata;
        if (addr == A_IE) ie_m <= wdata[3:0];
      end
      if (rd) begin
        case (addr)
          A_LO:    exp_rd <= lo_m;
          A_HI:    exp_rd <= hi_m;
          A_IE:    exp_rd <= {4'h0, ie_m};
          A_ST:    exp_rd <= {4'h0, st_m};
          default: exp_rd <= 8'h00;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && irq_auto) chk("R10", {31'b0, irq}, {31'b0, |(st_m & ie_m)});

  task automatic wr_reg(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [8:0] a, input string req, input logic [7:0] exp);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk(req, {24'b0, rdata}, {24'b0, exp});
  endtask

  task automatic rd_model(input logic [8:0] a);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk("R7", {24'b0, rdata}, {24'b0, exp_rd});
  endtask

  task automatic set_occ(input int unsigned v);
    @(negedge clk); occ = 24'(v);
  endtask

  task automatic pulse(input bit qf);
    @(negedge clk); if (qf) q_ovf = 1'b1; else f_ovf = 1'b1;
    @(negedge clk); q_ovf = 1'b0; f_ovf = 1'b0;
  endtask

  function automatic int unsigned occ_at(input int k, input int unsigned h, input int unsigned l);
    case (k)
      0: return 0;
      1: return (l > 0) ? l - 1 : 0;
      2: return l;
      3: return h;
      4: return h + 1;
      5: return h + S;
      6: return h;
      7: return (h > 0) ? h - 1 : 0;
      8: return l;
      9: return (l > 0) ? l - 1 : 0;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, irq}, 32'd0);
    chk("R1", {24'b0, rdata}, 32'd0);
    rst_n = 1'b1;
    irq_auto = 1'b1;
    rd_reg(A_LO, "R1", 8'h00);
    rd_reg(A_HI, "R1", 8'h00);
    rd_reg(A_IE, "R1", 8'h00);
    rd_reg(A_ST, "R1", 8'h00);

    // program without causing crossings
    wr_reg(A_HI, 8'h03);
    set_occ(2 * S);
    wr_reg(A_LO, 8'h01);
    wr_reg(A_IE, 8'hFF);
    rd_reg(A_HI, "R2", 8'h03);
    rd_reg(A_LO, "R2", 8'h01);
    rd_reg(A_IE, "R9", 8'h0F);
    rd_reg(A_ST, "R7", 8'h00);

    // high crossing, equality is not above
    set_occ(3 * S);
    @(negedge clk); chk("R3", {31'b0, irq}, 32'd0);
    rd_reg(A_ST, "R3", 8'h00);
    set_occ(3 * S + 1);
    chk("R3", {31'b0, irq}, 32'd0);
    @(negedge clk); chk("R3", {31'b0, irq}, 32'd1);
    rd_reg(A_ST, "R3", 8'h02);
    chk("R7", {31'b0, irq}, 32'd0);

    // staying above does not retrigger
    set_occ(3 * S + 100);
    repeat (3) @(negedge clk);
    rd_reg(A_ST, "R4", 8'h00);

    // low crossing, equality is not below
    set_occ(S);
    @(negedge clk);
    rd_reg(A_ST, "R5", 8'h00);
    set_occ(S - 1);
    @(negedge clk);
    rd_reg(A_ST, "R5", 8'h01);

    // overflow pulses
    pulse(1'b1);
    rd_reg(A_ST, "R6", 8'h04);
    pulse(1'b0);
    rd_reg(A_ST, "R6", 8'h08);

    // sticky, cleared only by a status read
    pulse(1'b1);
    repeat (4) @(negedge clk);
    rd_reg(A_IE, "R7", 8'h0F);
    rd_reg(A_LO, "R7", 8'h01);
    rd_reg(A_ST, "R7", 8'h04);
    rd_reg(A_ST, "R7", 8'h00);

    // event coincident with the clearing read
    @(negedge clk); rd = 1'b1; addr = A_ST; q_ovf = 1'b1;
    @(negedge clk); rd = 1'b0; q_ovf = 1'b0;
    chk("R8", {24'b0, rdata}, 32'h00);
    rd_reg(A_ST, "R8", 8'h04);

    // interrupt masking
    wr_reg(A_IE, 8'h04);
    @(negedge clk); f_ovf = 1'b1;
    @(negedge clk); f_ovf = 1'b0; chk("R10", {31'b0, irq}, 32'd0);
    @(negedge clk); q_ovf = 1'b1;
    @(negedge clk); q_ovf = 1'b0; chk("R10", {31'b0, irq}, 32'd1);
    rd_reg(A_ST, "R10", 8'h0C);
    chk("R10", {31'b0, irq}, 32'd0);
    wr_reg(A_IE, 8'h00);
    pulse(1'b1);
    chk("R10", {31'b0, irq}, 32'd0);
    rd_reg(A_ST, "R10", 8'h04);

    // read path, unused bits, ignored writes
    rd_reg(9'h100, "R11", 8'h00);
    rd_reg(A_HI, "R11", 8'h03);
    repeat (2) @(negedge clk);
    chk("R11", {24'b0, rdata}, 32'h03);
    wr_reg(A_IE, 8'hA5);
    rd_reg(A_IE, "R9", 8'h05);
    wr_reg(A_ST, 8'hFF);
    rd_reg(A_ST, "R9", 8'h00);
    wr_reg(A_HI, 8'hFF);
    rd_reg(A_HI, "R2", 8'hFF);

    // sweep over a grid of thresholds and boundary occupancies
    for (int h = 0; h < 8; h++) begin
      for (int l = 0; l < 4; l++) begin
        wr_reg(A_HI, 8'(h));
        wr_reg(A_LO, 8'(l));
        wr_reg(A_IE, 8'((h + l) & 15));
        rd_model(A_ST);
        for (int k = 0; k < 10; k++) begin
          set_occ(occ_at(k, h * S, l * S));
          if (k == 3) q_ovf = 1'b1;
          if (k == 7) f_ovf = 1'b1;
          @(negedge clk); q_ovf = 1'b0; f_ovf = 1'b0;
          if (k % 3 == 2) rd_model(A_ST);
        end
        rd_model(A_ST);
      end
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule